// File: doc/BRIEF.md
# Card Bus Clock Divider

This block produces the card bus clock from the host kernel clock. It works entirely in the kernel clock domain. A divided clock level is produced together with single-cycle strobes that mark its rising and falling edges, so downstream logic can launch or capture data on either edge without a second clock domain. A divide value N of 1 or more gives a card clock of the kernel frequency over 2N, with N kernel cycles high and N low. N equal to zero selects pass-through, in which the pad multiplexer forwards the kernel clock itself. That state is signalled on a flag and both strobes are held high.

The divide value comes either directly from a programmed field or from a requested frequency in kHz, which the block turns into the smallest divider that does not exceed the request. Double-data-rate operation never uses pass-through. A request of zero slows the clock to its lowest rate and does not stop it. Only the two non-running power states stop the clock. A new divide value is adopted only where a low phase ends, so no shortened pulse reaches the card. The block also decodes the bus timing mode into a high-speed bus flag and into the choice of sampling from the returned feedback clock.

Top module: `card_clk_div`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every output is 0, including `act_div`.
- R2: The clock runs only when `pwr_state` is 2'b11. Codes 2'b00 (off), 2'b10 (power cycle) and 2'b01 stop it. In the cycle after such a code is sampled, `ck_lvl`, `ck_rise`, `ck_fall` and `ck_bypass` are 0. After power returns, the first high phase starts after N low cycles.
- R3: With active divider N of 1 or more and power on, `ck_lvl` is high for exactly N cycles and then low for exactly N cycles (period 2N).
- R4: With active divider 0 and power on, `ck_bypass` is 1, `ck_lvl` is 0, and `ck_rise` and `ck_fall` are both 1 in every cycle.
- R5: In field mode (`use_freq`=0), the divider is `div_field`. When `ddr_en` is 1, a field of 0 is replaced by 1.
- R6: In frequency mode (`use_freq`=1, `req_khz` nonzero), the divider is ceil(KERNEL_KHZ / (2 x `req_khz`)), saturated at 1023.
- R7: In frequency mode, `req_khz` = 0 gives divider 1023.
- R8: In frequency mode, `req_khz` >= KERNEL_KHZ gives divider 0 when `ddr_en` is 0, and divider 1 when `ddr_en` is 1.
- R9: While running divided, `act_div` changes only at the end of a low phase. It does so in the cycle `ck_lvl` rises, or in the cycle pass-through starts if the new value is 0, in which case `ck_lvl` stays low. Outside the run state, `act_div` follows the request in the next cycle.
- R10: `bus_hs` is 1 exactly one cycle after `bus_mode` is 4, 5, 6 or 7 (codes: 0 legacy, 1 high speed, 2 SDR12, 3 SDR25, 4 SDR50, 5 DDR50, 6 SDR104, 7 HS200).
- R11: `sample_fb` is 1 exactly one cycle after `bus_mode` is 6 or 7.
- R12: When divided, `ck_rise` is 1 only in the first high cycle of a phase, and `ck_fall` is 1 only in the first low cycle that follows a high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_state | input | 2 | Power state: 00 off, 10 power cycle, 11 on |
| ddr_en | input | 1 | Double-data-rate mode, forbids pass-through |
| bus_mode | input | 3 | Bus timing mode code |
| use_freq | input | 1 | 1 selects the frequency request, 0 the divider field |
| div_field | input | 10 | Programmed divide value |
| req_khz | input | 18 | Requested card frequency in kHz |
| ck_lvl | output | 1 | Divided card clock level |
| ck_rise | output | 1 | Rising-edge strobe |
| ck_fall | output | 1 | Falling-edge strobe |
| ck_bypass | output | 1 | Pass-through of the kernel clock is active |
| act_div | output | 10 | Divide value currently in effect |
| bus_hs | output | 1 | High-speed bus flag |
| sample_fb | output | 1 | Sample data with the feedback clock |

## Verification
A divide-value update can arrive in the same cycle in which the low phase expires. The bench provokes this by toggling `div_field` at every offset within short periods, including to and from zero. A cycle-accurate reference model then decides whether the old or the new value governs the next phase, and confirms that pass-through entered at that point raises no level. Power removal that coincides with a phase boundary is driven the same way. The model requires the stop to take precedence over the edge.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;

    typedef enum logic [1:0] {
        PWR_OFF   = 2'b00,
        PWR_RSVD  = 2'b01,
        PWR_CYCLE = 2'b10,
        PWR_ON    = 2'b11
    } pwr_e;

    typedef enum logic [2:0] {
        BM_LEGACY = 3'd0,
        BM_HS     = 3'd1,
        BM_SDR12  = 3'd2,
        BM_SDR25  = 3'd3,
        BM_SDR50  = 3'd4,
        BM_DDR50  = 3'd5,
        BM_SDR104 = 3'd6,
        BM_HS200  = 3'd7
    } bus_mode_e;

    typedef struct packed {
        logic hs;
        logic fb;
    } mode_flags_t;

    function automatic mode_flags_t decode_mode(input bus_mode_e m);
        mode_flags_t f;
        f.hs = (m >= BM_SDR50);
        f.fb = (m == BM_SDR104) || (m == BM_HS200);
        return f;
    endfunction

endpackage

// File: rtl/card_clk_req.sv
module card_clk_req #(
    parameter int DIV_W      = 10,
    parameter int FREQ_W     = 18,
    parameter int KERNEL_KHZ = 200000
) (
    input  logic              use_freq,
    input  logic              ddr_en,
    input  logic [DIV_W-1:0]  div_field,
    input  logic [FREQ_W-1:0] req_khz,
    output logic [DIV_W-1:0]  req_div
);
    localparam logic [DIV_W-1:0] DIV_MAX = '1;
    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);
    localparam logic [31:0]      KHZ32   = 32'(KERNEL_KHZ);

    logic [31:0] freq32;
    logic [31:0] twice32;
    logic [31:0] quot;
    logic        sat;
    logic [DIV_W-1:0] from_freq;
    logic [DIV_W-1:0] from_field;

    always_comb begin
        freq32  = 32'(req_khz);
        twice32 = {freq32[30:0], 1'b0};
        quot    = '0;
        if (req_khz != '0) begin
            quot = (KHZ32 + twice32 - 32'd1) / twice32;
        end
        sat = |quot[31:DIV_W];
        if (req_khz == '0) begin
            from_freq = DIV_MAX;
        end else if (freq32 >= KHZ32) begin
            from_freq = ddr_en ? DIV_ONE : '0;
        end else if (sat) begin
            from_freq = DIV_MAX;
        end else begin
            from_freq = quot[DIV_W-1:0];
        end
    end

    always_comb begin
        if (ddr_en && (div_field == '0)) begin
            from_field = DIV_ONE;
        end else begin
            from_field = div_field;
        end
    end

    assign req_div = use_freq ? from_freq : from_field;

endmodule

// File: rtl/card_clk_mode.sv
module card_clk_mode
    import card_clk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] bus_mode,
    output logic       bus_hs,
    output logic       sample_fb
);
    mode_flags_t flags_d;
    mode_flags_t flags_q;

    assign flags_d = decode_mode(bus_mode_e'(bus_mode));

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign bus_hs    = flags_q.hs;
    assign sample_fb = flags_q.fb;

endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] req_div,
    output logic             ck_lvl,
    output logic             ck_rise,
    output logic             ck_fall,
    output logic             ck_bypass,
    output logic [DIV_W-1:0] act_div
);
    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

    logic [DIV_W-1:0] act_q;
    logic [DIV_W-1:0] cnt_q;
    logic             lvl_q;
    logic             rise_q;
    logic             fall_q;
    logic             run_q;
    logic             phase_end;

    assign phase_end = (cnt_q == (act_q - DIV_ONE));

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            cnt_q  <= '0;
            lvl_q  <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            run_q  <= run;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
            if (!run) begin
                act_q <= req_div;
                cnt_q <= '0;
                lvl_q <= 1'b0;
            end else if (act_q == '0) begin
                act_q <= req_div;
                cnt_q <= '0;
                lvl_q <= 1'b0;
            end else if (phase_end) begin
                cnt_q <= '0;
                if (lvl_q) begin
                    lvl_q  <= 1'b0;
                    fall_q <= 1'b1;
                end else if (req_div == '0) begin
                    act_q <= '0;
                end else begin
                    act_q  <= req_div;
                    lvl_q  <= 1'b1;
                    rise_q <= 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + DIV_ONE;
            end
        end
    end

    assign ck_bypass = run_q && (act_q == '0);
    assign ck_lvl    = lvl_q;
    assign ck_rise   = rise_q || ck_bypass;
    assign ck_fall   = fall_q || ck_bypass;
    assign act_div   = act_q;

endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
    import card_clk_pkg::*;
#(
    parameter int DIV_W      = 10,
    parameter int FREQ_W     = 18,
    parameter int KERNEL_KHZ = 200000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        pwr_state,
    input  logic              ddr_en,
    input  logic [2:0]        bus_mode,
    input  logic              use_freq,
    input  logic [DIV_W-1:0]  div_field,
    input  logic [FREQ_W-1:0] req_khz,
    output logic              ck_lvl,
    output logic              ck_rise,
    output logic              ck_fall,
    output logic              ck_bypass,
    output logic [DIV_W-1:0]  act_div,
    output logic              bus_hs,
    output logic              sample_fb
);
    logic [DIV_W-1:0] req_div;
    logic             run;

    assign run = (pwr_e'(pwr_state) == PWR_ON);

    card_clk_req #(
        .DIV_W      (DIV_W),
        .FREQ_W     (FREQ_W),
        .KERNEL_KHZ (KERNEL_KHZ)
    ) u_req (
        .use_freq  (use_freq),
        .ddr_en    (ddr_en),
        .div_field (div_field),
        .req_khz   (req_khz),
        .req_div   (req_div)
    );

    card_clk_gen #(
        .DIV_W (DIV_W)
    ) u_gen (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .req_div   (req_div),
        .ck_lvl    (ck_lvl),
        .ck_rise   (ck_rise),
        .ck_fall   (ck_fall),
        .ck_bypass (ck_bypass),
        .act_div   (act_div)
    );

    card_clk_mode u_mode (
        .clk       (clk),
        .rst       (rst),
        .bus_mode  (bus_mode),
        .bus_hs    (bus_hs),
        .sample_fb (sample_fb)
    );

endmodule

// File: rtl/card_clk_div_chk.sv
module card_clk_div_chk #(
    parameter int DIV_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       pwr_state,
    input logic             ddr_en,
    input logic             ck_lvl,
    input logic             ck_rise,
    input logic             ck_fall,
    input logic             ck_bypass,
    input logic [DIV_W-1:0] act_div,
    input logic             bus_hs,
    input logic             sample_fb
);
    logic [DIV_W:0] hi_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len <= '0;
        end else if (ck_lvl) begin
            hi_len <= hi_len + 1'b1;
        end else begin
            hi_len <= '0;
        end
    end

    AST_STOP_ON_POWER_DOWN: assert property (@(posedge clk) disable iff (rst)
        (pwr_state != 2'b11) |=> (!ck_lvl && !ck_rise && !ck_fall && !ck_bypass)); // R2

    AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (rst)
        ($fell(ck_lvl) && $past(pwr_state) == 2'b11) |-> ({1'b0, act_div} == hi_len)); // R3

    AST_BYPASS_STROBES: assert property (@(posedge clk) disable iff (rst)
        ck_bypass |-> (ck_rise && ck_fall && !ck_lvl)); // R4

    AST_DDR_NO_BYPASS: assert property (@(posedge clk) disable iff (rst)
        $past(ddr_en) |-> !ck_bypass); // R5

    AST_UPDATE_AT_LOW_END: assert property (@(posedge clk) disable iff (rst)
        ($past(pwr_state) == 2'b11 && $past(act_div) != '0 && act_div != $past(act_div))
        |-> (!$past(ck_lvl) && (ck_rise || ck_bypass))); // R9

    AST_FB_IMPLIES_HS: assert property (@(posedge clk) disable iff (rst)
        sample_fb |-> bus_hs); // R11

    AST_RISE_IS_EDGE: assert property (@(posedge clk) disable iff (rst)
        (ck_rise && !ck_bypass) |-> (ck_lvl && !$past(ck_lvl))); // R12

    AST_FALL_IS_EDGE: assert property (@(posedge clk) disable iff (rst)
        (ck_fall && !ck_bypass) |-> (!ck_lvl && $past(ck_lvl))); // R12

endmodule

bind card_clk_div card_clk_div_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_state (pwr_state),
    .ddr_en    (ddr_en),
    .ck_lvl    (ck_lvl),
    .ck_rise   (ck_rise),
    .ck_fall   (ck_fall),
    .ck_bypass (ck_bypass),
    .act_div   (act_div),
    .bus_hs    (bus_hs),
    .sample_fb (sample_fb)
);

// File: tb/test_card_clk_div.sv
module test_card_clk_div;
    localparam int DW   = 10;
    localparam int FW   = 18;
    localparam int KKHZ = 200000;
    localparam int WD_LIMIT = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    pwr_state = 2'b00;
    logic          ddr_en = 1'b0;
    logic [2:0]    bus_mode = 3'd0;
    logic          use_freq = 1'b0;
    logic [DW-1:0] div_field = '0;
    logic [FW-1:0] req_khz = '0;
    logic          ck_lvl, ck_rise, ck_fall, ck_bypass, bus_hs, sample_fb;
    logic [DW-1:0] act_div;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit cmp_en = 1'b0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    card_clk_div #(.DIV_W(DW), .FREQ_W(FW), .KERNEL_KHZ(KKHZ)) i_card_clk_div (
        .clk(clk), .rst(rst), .pwr_state(pwr_state), .ddr_en(ddr_en),
        .bus_mode(bus_mode), .use_freq(use_freq), .div_field(div_field),
        .req_khz(req_khz), .ck_lvl(ck_lvl), .ck_rise(ck_rise), .ck_fall(ck_fall),
        .ck_bypass(ck_bypass), .act_div(act_div), .bus_hs(bus_hs), .sample_fb(sample_fb)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected divider from the requirements (R5..R8)
    function automatic int exp_div(input bit uf, input int fld, input int khz, input bit ddr);
        int d;
        if (!uf) return (fld == 0 && ddr) ? 1 : fld;
        if (khz == 0) return 1023;
        if (khz >= KKHZ) return ddr ? 1 : 0;
        d = (KKHZ + 2 * khz - 1) / (2 * khz);
        return (d > 1023) ? 1023 : d;
    endfunction

    // behavioural reference
    int m_act, m_left;
    bit m_lvl, m_rise, m_fall, m_run, m_hs, m_fb;

    always @(posedge clk) begin
        int r;
        r = exp_div(use_freq, int'(div_field), int'(req_khz), ddr_en);
        if (rst) begin
            m_act = 0; m_left = -1; m_lvl = 0; m_rise = 0; m_fall = 0;
            m_run = 0; m_hs = 0; m_fb = 0;
        end else begin
            m_hs = (bus_mode >= 3'd4);
            m_fb = (bus_mode == 3'd6) || (bus_mode == 3'd7);
            m_rise = 0; m_fall = 0;
            m_run = (pwr_state == 2'b11);
            if (!m_run || m_act == 0) begin
                m_act = r; m_lvl = 0; m_left = -1;
            end else begin
                if (m_left < 0) m_left = m_act;
                if (m_left > 1) m_left--;
                else if (m_lvl) begin m_lvl = 0; m_fall = 1; m_left = m_act; end
                else if (r == 0) begin m_act = 0; m_left = -1; end
                else begin m_act = r; m_lvl = 1; m_rise = 1; m_left = m_act; end
            end
        end
    end

    always @(negedge clk) begin
        bit eb;
        if (!rst && cmp_en) begin
            eb = m_run && (m_act == 0);
            chk("R3 ck_lvl", int'(ck_lvl), int'(m_lvl));
            chk("R12 ck_rise", int'(ck_rise), int'(m_rise || eb));
            chk("R12 ck_fall", int'(ck_fall), int'(m_fall || eb));
            chk("R4 ck_bypass", int'(ck_bypass), int'(eb));
            chk("R9 act_div", int'(act_div), m_act);
            chk("R10 bus_hs", int'(bus_hs), int'(m_hs));
            chk("R11 sample_fb", int'(sample_fb), int'(m_fb));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d cycles expected=<%0d", cyc, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic settle_div(input string tag, input int exp);
        pwr_state = 2'b10;
        wait_n(2);
        chk(tag, int'(act_div), exp);
        pwr_state = 2'b11;
        wait_n(12);
    endtask

    initial begin
        rst = 1'b1;
        wait_n(3);
        chk("R1 reset lvl", int'(ck_lvl), 0);
        chk("R1 reset strobes", int'(ck_rise | ck_fall), 0);
        chk("R1 reset bypass", int'(ck_bypass), 0);
        chk("R1 reset act_div", int'(act_div), 0);
        chk("R1 reset mode flags", int'(bus_hs | sample_fb), 0);
        rst = 1'b0;
        cmp_en = 1'b1;
        wait_n(1);
        chk("R1 after reset act_div", int'(act_div), 0);

        // divided run, N=3
        div_field = 10'd3;
        wait_n(2);
        pwr_state = 2'b11;
        wait_n(40);

        // R3: measure phase lengths with N=6
        div_field = 10'd6;
        wait_n(16);
        begin
            int hi, lo;
            hi = 0; lo = 0;
            while (!ck_rise) @(negedge clk);
            while (ck_lvl) begin hi++; @(negedge clk); end
            while (!ck_lvl) begin lo++; @(negedge clk); end
            chk("R3 high length N=6", hi, 6);
            chk("R3 low length N=6", lo, 6);
        end

        // R9: change requested while high is deferred
        while (!ck_lvl) @(negedge clk);
        div_field = 10'd4;
        @(negedge clk);
        chk("R9 deferred while high", int'(act_div), 6);
        while (!ck_rise) @(negedge clk);
        chk("R9 adopted at rise", int'(act_div), 4);

        // R9: update at every offset, incl. to and from bypass
        for (int off = 0; off < 8; off++) begin
            div_field = (off % 3 == 0) ? 10'd0 : ((off % 2 == 0) ? 10'd2 : 10'd1);
            wait_n(off + 1);
        end
        div_field = 10'd2;
        wait_n(10);

        // R4: bypass
        div_field = 10'd0;
        wait_n(10);
        chk("R4 bypass flag", int'(ck_bypass), 1);
        chk("R4 bypass strobes", int'(ck_rise & ck_fall), 1);

        // R2: power down while high stops next cycle
        div_field = 10'd5;
        wait_n(14);
        while (!ck_lvl) @(negedge clk);
        pwr_state = 2'b00;
        @(negedge clk);
        chk("R2 stopped lvl", int'(ck_lvl), 0);
        chk("R2 stopped strobes", int'(ck_rise | ck_fall | ck_bypass), 0);
        pwr_state = 2'b01;
        wait_n(3);
        chk("R2 reserved code stops", int'(ck_lvl | ck_rise), 0);
        pwr_state = 2'b11;
        wait_n(20);

        // R5: DDR forbids bypass
        ddr_en = 1'b1;
        div_field = 10'd0;
        settle_div("R5 ddr field zero", 1);
        chk("R5 no bypass in ddr", int'(ck_bypass), 0);
        ddr_en = 1'b0;
        div_field = 10'd7;
        settle_div("R5 field value", 7);

        // frequency path
        use_freq = 1'b1;
        req_khz = 18'd400;    settle_div("R6 400kHz", 250);
        req_khz = 18'd25000;  settle_div("R6 25MHz", 4);
        req_khz = 18'd150000; settle_div("R6 150MHz rounds up", 1);
        req_khz = 18'd50;     settle_div("R6 saturates", 1023);
        req_khz = 18'd0;      settle_div("R7 zero request", 1023);
        req_khz = 18'd200000; settle_div("R8 full rate bypass", 0);
        chk("R8 bypass active", int'(ck_bypass), 1);
        ddr_en = 1'b1;
        req_khz = 18'd250000; settle_div("R8 full rate ddr", 1);
        ddr_en = 1'b0;
        use_freq = 1'b0;

        // R10/R11 mode decode
        for (int m = 0; m < 8; m++) begin
            bus_mode = 3'(m);
            wait_n(2);
            chk("R10 bus_hs decode", int'(bus_hs), (m >= 4) ? 1 : 0);
            chk("R11 sample_fb decode", int'(sample_fb), (m == 6 || m == 7) ? 1 : 0);
        end

        // power stop coinciding with a boundary, N=1
        div_field = 10'd1;
        wait_n(6);
        for (int off = 0; off < 4; off++) begin
            pwr_state = 2'b10;
            wait_n(1);
            pwr_state = 2'b11;
            wait_n(off + 2);
        end
        wait_n(5);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule